// File: doc/BRIEF.md
# Sector decoder run/stop controller

This block is the run control for a sector-based stream decoder. Software sets and reads three control bits through an 8-bit register port: a decode enable, a subcode enable and a force-stop bit. The block turns those bits into a decode-active output and a subcode-active output. It does this using three event inputs from the datapath: a sync-detected pulse, an end-of-sector pulse and an abnormal-condition pulse.

Setting the decode enable only arms the decoder. Decoding begins at the next detected sync. Clearing the enable while a sector is in progress is a graceful stop: the current sector finishes and decoding then halts. Writing the force-stop bit aborts decoding at once and clears both enables. The enables stay locked at zero until software clears the force-stop bit with a separate write. An abnormal-condition pulse also stops decoding and clears both enables.

Top module: `sector_run_ctl`

## Requirements
- R1: After reset, the register reads 0x00, and decode_active and subcode_active are 0.
- R2: The register layout is: bit 7 is the subcode enable, bit 6 is the decode enable, bit 5 is force stop, and bits 4 to 0 are reserved. The reserved bits always read as 0, whatever value is written to them.
- R3: While not active, with decode enable at 1 in the register and force stop at 0, a sync_det pulse makes decode_active 1 from the following clock edge. Without a sync pulse, decode_active stays 0.
- R4: When decode enable is 0 while decoding is active, decode_active stays 1 until a sector_end pulse arrives, and falls at the edge after that pulse.
- R5: A sector_end pulse while decode enable is 1 leaves decode_active at 1.
- R6: A write with bit 5 = 1 drops decode_active at that same write edge. The register then reads 0x20, with both enables cleared.
- R7: While force stop reads 1, or is being written to 1, written enable bits are held at 0, and sync_det does not start decoding.
- R8: After a write that clears force stop, a later write of decode enable followed by a sync pulse starts decoding again.
- R9: An abnormal pulse makes decode_active 0 at the next edge and clears both enable bits.
- R10: When an abnormal pulse and a register write land in the same cycle, the hardware clear of the enable bits wins.
- R11: subcode_active is 1 exactly when decoding is active and the subcode enable bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| sync_det | input | 1 | Valid sync code seen (one-cycle pulse) |
| sector_end | input | 1 | Current sector finished (one-cycle pulse) |
| abnormal | input | 1 | Abnormal condition, automatic stop (one-cycle pulse) |
| decode_active | output | 1 | Decoder running |
| subcode_active | output | 1 | Subcode processing running |

## Verification
The start path is tried in two ways. Enable is held without sync, then sync is given, which separates arming from starting. Sector-end pulses are sent with the enable both set and cleared, which separates a graceful stop from a spurious one. The force-stop tests write enables while the stop bit is set and send sync in the locked state. They then release the stop bit and restart, which shows whether the lock exists and whether it is released. An abnormal pulse is also sent in the same cycle as an enabling write, to confirm that the hardware clear has priority.

// File: rtl/sector_run_ctl.sv
module sector_run_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       sync_det,
  input  logic       sector_end,
  input  logic       abnormal,
  output logic       decode_active,
  output logic       subcode_active
);
  localparam int SUB_BIT  = 7;
  localparam int DEC_BIT  = 6;
  localparam int STOP_BIT = 5;

  logic sub_q, dec_q, stop_q, run_q;
  logic stop_wr, locked, run_nxt;

  assign stop_wr = wr_en & wr_data[STOP_BIT];
  assign locked  = stop_q | wr_data[STOP_BIT];

  assign run_nxt = (stop_q | stop_wr | abnormal) ? 1'b0 :
                   run_q ? ~(sector_end & ~dec_q) :
                   (dec_q & sync_det);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sub_q  <= 1'b0;
      dec_q  <= 1'b0;
      stop_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      if (wr_en) begin
        stop_q <= wr_data[STOP_BIT];
        dec_q  <= wr_data[DEC_BIT] & ~locked;
        sub_q  <= wr_data[SUB_BIT] & ~locked;
      end
      if (abnormal) begin
        dec_q <= 1'b0;
        sub_q <= 1'b0;
      end
      run_q <= run_nxt;
    end
  end

  assign rd_data        = {sub_q, dec_q, stop_q, 5'b00000};
  assign decode_active  = run_q;
  assign subcode_active = run_q & sub_q;
endmodule

module sector_run_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       sync_det,
  input logic       sector_end,
  input logic       abnormal,
  input logic       decode_active,
  input logic       subcode_active
);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[4:0] == 5'b0);

  a_r3_start_needs_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(decode_active) |-> $past(sync_det));

  a_r4_fall_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(decode_active) |-> $past(sector_end | abnormal | rd_data[5] | (wr_en & wr_data[5])));

  a_r6_force_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[5]) |=> (!decode_active && rd_data[7:5] == 3'b001));

  a_r7_locked: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[5] |-> (rd_data[7:6] == 2'b00 && !decode_active));

  a_r9_abnormal_stop: assert property (@(posedge clk) disable iff (!rst_n)
    abnormal |=> (!decode_active && rd_data[7:6] == 2'b00));

  a_r11_subcode: assert property (@(posedge clk) disable iff (!rst_n)
    subcode_active == (decode_active && rd_data[7]));
endmodule

bind sector_run_ctl sector_run_ctl_chk u_chk (.*);

// File: tb/tb_sector_run_ctl.sv
module tb_sector_run_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       sync_det = 1'b0, sector_end = 1'b0, abnormal = 1'b0;
  logic [7:0] rd_data;
  logic       decode_active, subcode_active;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  // behavioural reference state
  int m_sub = 0, m_dec = 0, m_stop = 0, m_run = 0;

  always #4 clk = ~clk;

  sector_run_ctl dut (.*);

  always @(posedge clk) begin
    int new_run;
    if (!rst_n) begin
      m_sub = 0; m_dec = 0; m_stop = 0; m_run = 0;
    end else begin
      new_run = m_run;
      if (m_run != 0 && sector_end && m_dec == 0) new_run = 0;
      if (m_run == 0 && m_dec != 0 && sync_det) new_run = 1;
      if (m_stop != 0 || (wr_en && wr_data[5]) || abnormal) new_run = 0;
      if (wr_en) begin
        if (m_stop != 0 || wr_data[5]) begin m_dec = 0; m_sub = 0; end
        else begin m_dec = int'(wr_data[6]); m_sub = int'(wr_data[7]); end
        m_stop = int'(wr_data[5]);
      end
      if (abnormal) begin m_dec = 0; m_sub = 0; end
      m_run = new_run;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // per-cycle model compare, away from the active edge
  always @(negedge clk) if (rst_n && !done) begin
    logic [7:0] exp_rd;
    exp_rd = {m_sub[0], m_dec[0], m_stop[0], 5'b0};
    check(rd_data == exp_rd, "R2 model rd_data", rd_data, exp_rd);
    check(decode_active == m_run[0], "R3 model decode_active", decode_active, m_run);
    check(subcode_active == (m_run[0] & m_sub[0]), "R11 model subcode_active",
          subcode_active, m_run & m_sub);
  end

  task automatic cyc(input bit we, input logic [7:0] wd, input bit sy, input bit se, input bit ab);
    wr_en = we; wr_data = wd; sync_det = sy; sector_end = se; abnormal = ab;
    @(negedge clk);
    wr_en = 0; wr_data = 8'h00; sync_det = 0; sector_end = 0; abnormal = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    $display("FAIL watchdog expired actual=0 expected=1");
    n_fail++; n_checks++;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_data == 8'h00, "R1 reset rd_data", rd_data, 8'h00);
    check(decode_active == 0 && subcode_active == 0, "R1 reset outputs", decode_active, 0);

    cyc(1, 8'hDF, 0, 0, 0);
    check(rd_data == 8'hC0, "R2 reserved read zero", rd_data, 8'hC0);
    idle(3);
    check(decode_active == 0, "R3 no start without sync", decode_active, 0);
    cyc(0, 8'h00, 1, 0, 0);
    check(decode_active == 1, "R3 start on sync", decode_active, 1);
    check(subcode_active == 1, "R11 subcode with decode", subcode_active, 1);
    cyc(0, 8'h00, 0, 1, 0);
    check(decode_active == 1, "R5 sector end keeps running", decode_active, 1);
    cyc(1, 8'h00, 0, 0, 0);
    check(decode_active == 1, "R4 runs to sector end", decode_active, 1);
    check(subcode_active == 0, "R11 subcode off with enable", subcode_active, 0);
    idle(2);
    check(decode_active == 1, "R4 still running", decode_active, 1);
    cyc(0, 8'h00, 0, 1, 0);
    check(decode_active == 0, "R4 stop at sector end", decode_active, 0);

    cyc(1, 8'hC0, 0, 0, 0);
    cyc(0, 8'h00, 1, 0, 0);
    check(decode_active == 1, "R3 restart", decode_active, 1);
    cyc(1, 8'hE0, 0, 0, 0);
    check(decode_active == 0, "R6 forced stop immediate", decode_active, 0);
    check(rd_data == 8'h20, "R6 enables cleared", rd_data, 8'h20);
    cyc(1, 8'h60, 0, 0, 0);
    check(rd_data == 8'h20, "R7 enable blocked", rd_data, 8'h20);
    cyc(0, 8'h00, 1, 0, 0);
    check(decode_active == 0, "R7 sync ignored while stopped", decode_active, 0);
    cyc(1, 8'h00, 0, 0, 0);
    check(rd_data == 8'h00, "R8 stop released", rd_data, 8'h00);
    cyc(1, 8'h40, 0, 0, 0);
    cyc(0, 8'h00, 1, 0, 0);
    check(decode_active == 1, "R8 restart after release", decode_active, 1);
    check(subcode_active == 0, "R11 subcode off when bit 7 clear", subcode_active, 0);

    cyc(0, 8'h00, 0, 0, 1);
    check(decode_active == 0, "R9 abnormal stop", decode_active, 0);
    check(rd_data == 8'h00, "R9 enables cleared", rd_data, 8'h00);
    cyc(1, 8'hC0, 0, 0, 1);
    check(rd_data == 8'h00, "R10 hardware clear wins", rd_data, 8'h00);
    cyc(0, 8'h00, 1, 0, 0);
    check(decode_active == 0, "R10 no start after lost write", decode_active, 0);

    idle(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule